// File: doc/BRIEF.md
# Holdover Frequency Offset Controller

This block supplies the frequency word that a digital PLL's oscillator holds while the loop is in holdover. It watches the loop's 24-bit signed frequency word, which is presented together with a one-cycle update strobe. It keeps a registered copy of the latest word, and it runs two first-order averagers over that word: a slow one and a fast one. It also holds a software-written manual word and a word frozen at the instant holdover begins. Three select bits choose which of these four values drives the holdover output. One LSB of every word is 0.000011 ppm.

A separate read-select bit steers the 24-bit read port. With the bit at 0 the port returns the manual word as last written. With the bit at 1 it returns one of the two averages, chosen by the fast select bit. The latest loop word is always visible on its own output, so software can filter it and write the result back as a manual value. The averagers learn only while the loop is locked and holdover is off. The reset is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `hofs_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `cur_freq`, `hold_freq` and `rd_data` are all zero, because every register and accumulator starts at zero.
- R2: When `upd_stb` is high on a rising clock edge, `cur_freq` shows the `freq_in` of that edge from the next cycle onward. Without a strobe, `cur_freq` keeps its value.
- R3: Each averager keeps an accumulator `acc` of W+K+1 bits, where K is 12 for the slow averager and 8 for the fast one. On an update edge, `acc` becomes `acc + x - avg`, where x is `freq_in` sign-extended and `avg` is `acc` shifted arithmetically right by K. The output stays within the 24-bit signed range even under full-scale input.
- R4: An averager updates only on edges where `upd_stb`=1, `loop_locked`=1 and `hold_active`=0. On any other edge both averages keep their values.
- R5: With `sel_manual`=1, `hold_freq` equals the manual word, whatever the values of `sel_avg` and `sel_fast`.
- R6: With `sel_manual`=0 and `sel_avg`=0, `hold_freq` equals the value `cur_freq` had just before the clock edge at which `hold_active` was first sampled high (0 to 1). `sel_fast` has no effect in this mode.
- R7: With `sel_manual`=0 and `sel_avg`=1, `hold_freq` is the fast average when `sel_fast`=1 and the slow average when `sel_fast`=0.
- R8: `rd_data` is the manual word when `rd_avg`=0. When `rd_avg`=1 it is the fast average if `sel_fast`=1 and the slow average if `sel_fast`=0.
- R9: `wr_en`=1 on an edge loads `wr_data` into the manual word. A write leaves both averages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | Update strobe that qualifies `freq_in` |
| freq_in | input | 24 | Loop frequency word, two's complement |
| loop_locked | input | 1 | Loop lock indication; allows averaging |
| hold_active | input | 1 | Holdover in force; freezes averaging, and its rising edge captures the frozen word |
| sel_manual | input | 1 | Select the manual word as the holdover source |
| sel_avg | input | 1 | Select an averaged source rather than the frozen word |
| sel_fast | input | 1 | Choose the fast average over the slow one (holdover source and readback) |
| rd_avg | input | 1 | Readback select: 0 gives the manual word, 1 gives an average |
| wr_en | input | 1 | Write strobe for the manual word |
| wr_data | input | 24 | Manual word write data |
| rd_data | output | 24 | Readback value |
| hold_freq | output | 24 | Frequency word to hold during holdover |
| cur_freq | output | 24 | Latest strobed loop frequency word |

## Verification
The bench drives full-scale positive and negative words for thousands of strobes. An accumulator that is too narrow, or a shift that is logical instead of arithmetic, would wrap and flip the sign of an average. It keeps strobing while the loop is unlocked and while holdover is active. A gate that ignored either condition would let an average drift toward words the loop should not learn from. It moves `cur_freq` after holdover begins and switches `sel_fast` while the frozen source is selected. A capture that sampled on the level of `hold_active` rather than its edge, or a mux that looked at `sel_fast` in the frozen mode, would then show a different word. Readback is toggled between the manual word and the averages while writes land, which exposes a readback that follows the acquisition select or a write that disturbs an average.

// File: rtl/hofs_pkg.sv
package hofs_pkg;

  localparam int FREQ_W = 24;

  typedef enum logic [1:0] {
    SRC_MANUAL = 2'd0,
    SRC_FROZEN = 2'd1,
    SRC_SLOW   = 2'd2,
    SRC_FAST   = 2'd3
  } hold_src_e;

  // Manual dominates; otherwise the average bit picks frozen vs averaged.
  function automatic hold_src_e pick_src(input logic manual, input logic use_avg,
                                         input logic fast);
    if (manual)        return SRC_MANUAL;
    else if (!use_avg) return SRC_FROZEN;
    else if (fast)     return SRC_FAST;
    else               return SRC_SLOW;
  endfunction

endpackage

// File: rtl/hofs_iir.sv
module hofs_iir #(
  parameter int W = 24,
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] x,
  output logic [W-1:0] avg
);

  localparam int ACC_W = W + K + 1;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] x_ext, y_ext;
  logic                    live_q;

  // The average is the accumulator scaled down by 2^K; it stays within W bits.
  assign avg   = acc_q[K +: W];
  assign x_ext = {{(K+1){x[W-1]}}, x};
  assign y_ext = {{(K+1){avg[W-1]}}, avg};

  always_comb begin
    acc_d = acc_q;
    if (step) acc_d = acc_q + x_ext - y_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      live_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      live_q <= 1'b1;
    end
  end

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !step) |=> $stable(avg));

  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && step && ($signed(x) > $signed(avg))) |=> ($signed(avg) >= $signed($past(avg))));

  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && step && ($signed(x) < $signed(avg))) |=> ($signed(avg) <= $signed($past(avg))));

endmodule

// File: rtl/hofs_hold_sel.sv
module hofs_hold_sel
  import hofs_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_active,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] man,
  input  logic [W-1:0] slow_avg,
  input  logic [W-1:0] fast_avg,
  input  logic         sel_manual,
  input  logic         sel_avg,
  input  logic         sel_fast,
  output logic [W-1:0] hold_freq
);

  logic [W-1:0] cap_q, cap_d;
  logic         hold_d;
  logic         entry;
  logic         live_q;
  hold_src_e    src;

  assign entry = hold_active & ~hold_d;

  always_comb begin
    cap_d = cap_q;
    if (entry) cap_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      hold_d <= 1'b0;
      live_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      hold_d <= hold_active;
      live_q <= 1'b1;
    end
  end

  always_comb begin
    src = pick_src(sel_manual, sel_avg, sel_fast);
    unique case (src)
      SRC_MANUAL: hold_freq = man;
      SRC_FROZEN: hold_freq = cap_q;
      SRC_SLOW:   hold_freq = slow_avg;
      SRC_FAST:   hold_freq = fast_avg;
      default:    hold_freq = cap_q;
    endcase
  end

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && hold_active && !hold_d) |=> (cap_q == $past(cur)));

  p_frozen_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && hold_d) |=> $stable(cap_q));

endmodule

// File: rtl/hofs_ctrl.sv
module hofs_ctrl
  import hofs_pkg::*;
#(
  parameter int W          = FREQ_W,
  parameter int SLOW_SHIFT = 12,
  parameter int FAST_SHIFT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_stb,
  input  logic [W-1:0] freq_in,
  input  logic         loop_locked,
  input  logic         hold_active,
  input  logic         sel_manual,
  input  logic         sel_avg,
  input  logic         sel_fast,
  input  logic         rd_avg,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] hold_freq,
  output logic [W-1:0] cur_freq
);

  logic [W-1:0] cur_q, cur_d;
  logic [W-1:0] man_q, man_d;
  logic [W-1:0] slow_avg, fast_avg;
  logic         learn;
  logic         live_q;

  // Averagers learn only from a locked loop that is not in holdover.
  assign learn = upd_stb & loop_locked & ~hold_active;

  always_comb begin
    cur_d = cur_q;
    if (upd_stb) cur_d = freq_in;
    man_d = man_q;
    if (wr_en) man_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      man_q  <= '0;
      live_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      man_q  <= man_d;
      live_q <= 1'b1;
    end
  end

  assign cur_freq = cur_q;

  hofs_iir #(.W(W), .K(SLOW_SHIFT)) u_slow (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (learn),
    .x     (freq_in),
    .avg   (slow_avg)
  );

  hofs_iir #(.W(W), .K(FAST_SHIFT)) u_fast (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (learn),
    .x     (freq_in),
    .avg   (fast_avg)
  );

  hofs_hold_sel #(.W(W)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_active (hold_active),
    .cur         (cur_q),
    .man         (man_q),
    .slow_avg    (slow_avg),
    .fast_avg    (fast_avg),
    .sel_manual  (sel_manual),
    .sel_avg     (sel_avg),
    .sel_fast    (sel_fast),
    .hold_freq   (hold_freq)
  );

  // Readback follows its own select, independent of the acquisition bits.
  always_comb begin
    if (!rd_avg)       rd_data = man_q;
    else if (sel_fast) rd_data = fast_avg;
    else               rd_data = slow_avg;
  end

  p_cur_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && upd_stb) |=> (cur_freq == $past(freq_in)));

  p_cur_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !upd_stb) |=> $stable(cur_freq));

  p_wr_manual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && wr_en) ##1 sel_manual |-> (hold_freq == $past(wr_data)));

  p_rd_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && wr_en) ##1 !rd_avg |-> (rd_data == $past(wr_data)));

endmodule

// File: tb/hofs_ctrl_tb.sv
`timescale 1ns/1ps
module hofs_ctrl_tb;

  localparam int W  = 24;
  localparam int SK = 12;
  localparam int FK = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic upd_stb, loop_locked, hold_active;
  logic sel_manual, sel_avg, sel_fast, rd_avg, wr_en;
  logic [W-1:0] freq_in, wr_data;
  logic [W-1:0] rd_data, hold_freq, cur_freq;

  always #2.5 clk = ~clk;

  hofs_ctrl #(.W(W), .SLOW_SHIFT(SK), .FAST_SHIFT(FK)) u_dut (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .freq_in(freq_in),
    .loop_locked(loop_locked), .hold_active(hold_active),
    .sel_manual(sel_manual), .sel_avg(sel_avg), .sel_fast(sel_fast),
    .rd_avg(rd_avg), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hold_freq(hold_freq), .cur_freq(cur_freq)
  );

  // Behavioural reference: plain integers stepped once per edge.
  longint m_cur, m_cap, m_man, m_sacc, m_facc;
  bit     m_hold_prev;
  int     n_vec, n_bad;

  function automatic logic [W-1:0] w24(longint v);
    return v[W-1:0];
  endfunction

  function automatic logic [W-1:0] m_slow();
    return w24(m_sacc >>> SK);
  endfunction

  function automatic logic [W-1:0] m_fast();
    return w24(m_facc >>> FK);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_cap = 0; m_man = 0; m_sacc = 0; m_facc = 0; m_hold_prev = 0;
    end else begin
      longint x;
      x = longint'($signed(freq_in));
      if (hold_active && !m_hold_prev) m_cap = m_cur;
      if (upd_stb && loop_locked && !hold_active) begin
        m_sacc = m_sacc + x - (m_sacc >>> SK);
        m_facc = m_facc + x - (m_facc >>> FK);
      end
      if (upd_stb) m_cur = x;
      if (wr_en) m_man = longint'($signed(wr_data));
      m_hold_prev = hold_active;
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] eh;
    string tag;
    chk("R2 cur_freq", cur_freq, w24(m_cur));
    if (sel_manual)      begin eh = w24(m_man); tag = "R5 hold_freq manual"; end
    else if (!sel_avg)   begin eh = w24(m_cap); tag = "R6 hold_freq frozen"; end
    else if (sel_fast)   begin eh = m_fast();   tag = "R7 hold_freq fast";   end
    else                 begin eh = m_slow();   tag = "R7 hold_freq slow";   end
    chk(tag, hold_freq, eh);
    if (!rd_avg)       chk("R8 rd_data manual", rd_data, w24(m_man));
    else if (sel_fast) chk("R8 rd_data fast",   rd_data, m_fast());
    else               chk("R8 rd_data slow",   rd_data, m_slow());
  endtask

  // Stimulus knobs for the random cycles.
  int  g_base, g_spread, g_div;
  bit  g_rand_sel;

  task automatic cycle();
    @(negedge clk);
    compare_all();
    upd_stb = ($urandom_range(0, g_div - 1) == 0);
    freq_in = w24(longint'(g_base) + longint'($urandom_range(0, 2 * g_spread)) - g_spread);
    wr_en   = 1'b0;
    if (g_rand_sel) begin
      {sel_manual, sel_avg, sel_fast, rd_avg} = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) begin
        wr_en   = 1'b1;
        wr_data = w24(longint'($urandom));
      end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  logic [W-1:0] snap;

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0;
    upd_stb = 0; loop_locked = 0; hold_active = 0;
    sel_manual = 0; sel_avg = 0; sel_fast = 0; rd_avg = 0; wr_en = 0;
    freq_in = '0; wr_data = '0;
    g_base = 0; g_spread = 0; g_div = 1; g_rand_sel = 0;
    repeat (3) @(negedge clk);
    // R1: outputs at zero during reset and right after release
    chk("R1 cur_freq", cur_freq, '0);
    chk("R1 hold_freq", hold_freq, '0);
    chk("R1 rd_data", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cur_freq post", cur_freq, '0);
    rd_avg = 1'b1; #0.1;
    chk("R1 rd_data avg post", rd_data, '0);
    rd_avg = 1'b0;

    // R5/R9: manual write
    wr_en = 1'b1; wr_data = 24'h123456; sel_manual = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 manual write", hold_freq, 24'h123456);
    chk("R5 manual hold", hold_freq, 24'h123456);

    // Locked learning, random selects and writes
    loop_locked = 1'b1; g_base = 5000; g_spread = 300; g_div = 3; g_rand_sel = 1;
    run(3000);

    // R9: a write leaves averages untouched
    g_rand_sel = 0; g_div = 1000000;
    @(negedge clk); upd_stb = 0; rd_avg = 1; sel_fast = 1; #0.1; snap = rd_data;
    wr_en = 1'b1; wr_data = 24'hABCDEF;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 fast avg unchanged by write", rd_data, snap);

    // R6: enter holdover, then change current word and toggle sel_fast
    g_div = 2; g_base = -70000; g_spread = 5000;
    sel_manual = 0; sel_avg = 0;
    hold_active = 1'b1;
    run(400);
    for (int m = 0; m < 4; m++) begin
      {sel_manual, sel_avg, sel_fast} = 3'(m + 1);
      rd_avg = m[0];
      run(50);
    end
    // R4: averages frozen in holdover
    rd_avg = 1; sel_fast = 1; @(negedge clk); snap = rd_data;
    run(200);
    chk("R4 fast avg frozen in holdover", rd_data, snap);

    // R4: averages frozen while unlocked
    hold_active = 0; loop_locked = 0;
    sel_fast = 0; @(negedge clk); snap = rd_data;
    run(300);
    chk("R4 slow avg frozen while unlocked", rd_data, snap);

    // Re-entry capture after a random period
    loop_locked = 1; g_rand_sel = 1; g_base = 200; g_spread = 20000;
    run(1000);
    hold_active = 1; run(300); hold_active = 0; run(300);

    // R3: full-scale extremes
    g_rand_sel = 0; sel_manual = 0; sel_avg = 1; sel_fast = 1; rd_avg = 1;
    g_div = 1; g_spread = 0; g_base = 24'sh7FFFFF;
    run(6000);
    sel_fast = 0; @(negedge clk);
    chk("R3 slow avg positive after max input", 24'(rd_data[W-1]), 24'd0);
    sel_fast = 1;
    g_base = -(1 << 23);
    run(6000);
    sel_fast = 1; @(negedge clk);
    chk("R3 fast avg negative after min input", 24'(rd_data[W-1]), 24'd1);
    sel_fast = 0; g_rand_sel = 1; run(500);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule